// File: doc/BRIEF.md
# Eight-Channel Periodic Timeout Timer

The block holds a bank of independent down-counting channels that produce periodic timeout events. Each channel has a 16-bit reload value and a 16-bit down-counter. The counter steps down by one on each tick of a shared time base. When it steps past zero it takes the reload value again and sets that channel's timeout flag. A flag drives the channel's interrupt line whenever that channel's interrupt enable is set.

There are two shared time bases, A and B. Each is an 8-bit prescaler that emits a one-cycle tick every (prescale value + 1) clocks. A select bit per channel picks the time base that channel follows. A global run bit starts and stops the whole block. Per-channel enable bits start and stop single channels. Write-only force-load strobes restart a running channel from its reload value without waiting for an expiry.

Software reaches all of this through a plain synchronous register port. A write happens at the clock edge where the write strobe is high. The read data follows the address combinationally.

Top module: `multi_tick_timer`

## Requirements
- R1: After reset, every register reads zero, every counter reads zero and every interrupt output is low.
- R2: A channel that is running (run bit and its enable both set) decrements by one on each tick of its time base. On a tick where the counter is zero, the counter takes the reload value and the channel's timeout flag is set. A reload value L therefore gives one timeout every L+1 ticks.
- R3: Select bit i at 0 makes channel i follow time base A; at 1 it follows time base B. A time base with prescale value P ticks once every P+1 clocks while the run bit is set.
- R4: A channel's counter takes its reload value at the edge where the channel goes from not running to running. This happens when its enable bit is set while the run bit is on, or when the run bit is set while its enable bit is on. Counting starts on the next edge.
- R5: Writing a one to bit i of the force register loads the reload value into counter i at that edge, but only if channel i is running. Writing a zero to a bit has no effect. The force register always reads zero.
- R6: Timeout flags are cleared by writing a one to the matching bit of the flag register. Writing a zero leaves a flag unchanged. If a flag is set and cleared at the same edge, the set wins.
- R7: Clearing a channel's enable bit clears its flag at that same edge. The channel's counter then holds its value.
- R8: Clearing the run bit clears all flags at that edge. After that edge, all counters and both prescalers stop, and the prescalers wait at their prescale values.
- R9: Interrupt output i is high exactly when flag i and interrupt enable bit i are both set.
- R10: Register addresses:
  - 0x00: run bit, in bit 0.
  - 0x01: channel enables.
  - 0x02: time base selects.
  - 0x03: force strobes.
  - 0x04: flags.
  - 0x05: interrupt enables.
  - 0x06: prescale value of time base A.
  - 0x07: prescale value of time base B.
  - 0x08+i: reload value of channel i.
  - 0x10+i: counter of channel i, read-only.

  Bit i of every per-channel register belongs to channel i. Values written to the read/write registers read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| irq | output | 8 | Per-channel interrupt outputs |

## Verification
The bench builds the block with its default parameters: eight channels, 16-bit counters and 8-bit prescalers. It sets time base A to a prescale value of zero, so A ticks on every clock. That makes counter values predictable to the exact cycle, which brings the expiry reload and the force-load ordering within reach. It also allows a reload value of zero, which expires on every edge and so provides a flag set that coincides with a clear. Time base B runs at a prescale value of three. Counting over a window that is a whole multiple of its period checks the tick rate regardless of the prescaler's phase.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_RUN   = 5'h00;
  localparam logic [ADDR_W-1:0] A_CHEN  = 5'h01;
  localparam logic [ADDR_W-1:0] A_TBSEL = 5'h02;
  localparam logic [ADDR_W-1:0] A_FORCE = 5'h03;
  localparam logic [ADDR_W-1:0] A_FLAG  = 5'h04;
  localparam logic [ADDR_W-1:0] A_IEN   = 5'h05;
  localparam logic [ADDR_W-1:0] A_PRE_A = 5'h06;
  localparam logic [ADDR_W-1:0] A_PRE_B = 5'h07;
  localparam logic [ADDR_W-1:0] A_LOAD0 = 5'h08;
  localparam logic [ADDR_W-1:0] A_CNT0  = 5'h10;

  localparam int NUM_TB = 2;
endpackage

// File: rtl/pmt_prescaler.sv
module pmt_prescaler #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [PW-1:0] reload_i,
  output logic          tick_o
);
  logic [PW-1:0] pcnt_q, pcnt_d;

  always_comb begin
    if (!en_i || pcnt_q == '0) pcnt_d = reload_i;
    else                       pcnt_d = pcnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  assign tick_o = en_i & (pcnt_q == '0);

  // R8: while stopped the prescaler rests at its prescale value
  p_rest_at_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (pcnt_q == $past(reload_i)));

  // R3: between ticks the count steps down by one
  p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && pcnt_q != '0) |=> (!en_i || pcnt_q == $past(pcnt_q) - 1'b1));
endmodule

// File: rtl/pmt_channel.sv
module pmt_channel #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          kill_i,
  input  logic          tick_i,
  input  logic          load_now_i,
  input  logic          clr_i,
  input  logic [CW-1:0] load_val_i,
  output logic [CW-1:0] cnt_o,
  output logic          flag_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          flag_q, flag_d;
  logic          step, expire;

  assign step   = run_i & tick_i;
  assign expire = step & (cnt_q == '0);

  always_comb begin
    cnt_en = load_now_i | step;
    if (load_now_i || expire) cnt_d = load_val_i;
    else                      cnt_d = cnt_q - 1'b1;
  end

  always_comb begin
    if (kill_i)      flag_d = 1'b0;
    else if (expire) flag_d = 1'b1;
    else if (clr_i)  flag_d = 1'b0;
    else             flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;

  // R2: a tick on a non-zero count steps it down by one
  p_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_q != '0 && !load_now_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R2: a tick at zero reloads and raises the flag
  p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_q == '0 && !kill_i) |=> (cnt_q == $past(load_val_i) && flag_o));

  // R7: a stopped channel holds its count
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !load_now_i) |=> $stable(cnt_q));

  // R7: disabling clears the flag at once
  p_kill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    kill_i |=> !flag_o);

  // R6: a clear with no coincident expiry drops the flag
  p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !expire) |=> !flag_o);
endmodule

// File: rtl/multi_tick_timer.sv
module multi_tick_timer
  import pmt_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 16,
  parameter int PW  = 8,
  parameter int DW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [NCH-1:0]    irq
);
  // NCH up to 8 fits the per-channel address windows; CW and PW up to DW.

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  // register state
  logic           run_q,   run_d;
  logic [NCH-1:0] chen_q,  chen_d;
  logic [NCH-1:0] tbsel_q, tbsel_d;
  logic [NCH-1:0] ien_q,   ien_d;
  logic [PW-1:0]  pre_q [NUM_TB];
  logic [PW-1:0]  pre_d [NUM_TB];
  logic [CW-1:0]  load_q [NCH];
  logic [CW-1:0]  load_d [NCH];
  logic           cfg_en;

  always_comb begin
    run_d   = run_q;
    chen_d  = chen_q;
    tbsel_d = tbsel_q;
    ien_d   = ien_q;
    for (int t = 0; t < NUM_TB; t++) pre_d[t] = pre_q[t];
    for (int i = 0; i < NCH; i++)    load_d[i] = load_q[i];
    if (bus_we) begin
      case (bus_addr)
        A_RUN:   run_d      = bus_wdata[0];
        A_CHEN:  chen_d     = bus_wdata[NCH-1:0];
        A_TBSEL: tbsel_d    = bus_wdata[NCH-1:0];
        A_IEN:   ien_d      = bus_wdata[NCH-1:0];
        A_PRE_A: pre_d[0]   = bus_wdata[PW-1:0];
        A_PRE_B: pre_d[1]   = bus_wdata[PW-1:0];
        default: begin
          for (int i = 0; i < NCH; i++)
            if (bus_addr == A_LOAD0 + ADDR_W'(i)) load_d[i] = bus_wdata[CW-1:0];
        end
      endcase
    end
  end

  assign cfg_en = bus_we;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      run_q   <= 1'b0;
      chen_q  <= '0;
      tbsel_q <= '0;
      ien_q   <= '0;
      for (int t = 0; t < NUM_TB; t++) pre_q[t] <= '0;
      for (int i = 0; i < NCH; i++)    load_q[i] <= '0;
    end else if (cfg_en) begin
      run_q   <= run_d;
      chen_q  <= chen_d;
      tbsel_q <= tbsel_d;
      ien_q   <= ien_d;
      for (int t = 0; t < NUM_TB; t++) pre_q[t] <= pre_d[t];
      for (int i = 0; i < NCH; i++)    load_q[i] <= load_d[i];
    end
  end

  // channel strobes
  logic [NCH-1:0] act_q, act_d, start, force_ld, clr, load_now, kill;

  assign act_q    = {NCH{run_q}} & chen_q;
  assign act_d    = {NCH{run_d}} & chen_d;
  assign start    = act_d & ~act_q;
  assign force_ld = (bus_we && bus_addr == A_FORCE) ? (bus_wdata[NCH-1:0] & act_q) : '0;
  assign clr      = (bus_we && bus_addr == A_FLAG)  ? bus_wdata[NCH-1:0] : '0;
  assign load_now = start | force_ld;
  assign kill     = ~act_d;

  // shared time bases
  logic [NUM_TB-1:0] tb_tick;

  for (genvar t = 0; t < NUM_TB; t++) begin : g_tb
    pmt_prescaler #(.PW(PW)) u_pre (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .en_i     (run_q),
      .reload_i (pre_q[t]),
      .tick_o   (tb_tick[t])
    );
  end

  // channels
  logic [CW-1:0]  cnt [NCH];
  logic [NCH-1:0] flags;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic ch_tick;
    assign ch_tick = tbsel_q[i] ? tb_tick[1] : tb_tick[0];

    pmt_channel #(.CW(CW)) u_ch (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .run_i      (act_q[i]),
      .kill_i     (kill[i]),
      .tick_i     (ch_tick),
      .load_now_i (load_now[i]),
      .clr_i      (clr[i]),
      .load_val_i (load_q[i]),
      .cnt_o      (cnt[i]),
      .flag_o     (flags[i])
    );
  end

  assign irq = flags & ien_q;

  // read path
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_RUN:   bus_rdata[0]       = run_q;
      A_CHEN:  bus_rdata[NCH-1:0] = chen_q;
      A_TBSEL: bus_rdata[NCH-1:0] = tbsel_q;
      A_FLAG:  bus_rdata[NCH-1:0] = flags;
      A_IEN:   bus_rdata[NCH-1:0] = ien_q;
      A_PRE_A: bus_rdata[PW-1:0]  = pre_q[0];
      A_PRE_B: bus_rdata[PW-1:0]  = pre_q[1];
      default: begin
        for (int i = 0; i < NCH; i++) begin
          if (bus_addr == A_LOAD0 + ADDR_W'(i)) bus_rdata[CW-1:0] = load_q[i];
          if (bus_addr == A_CNT0  + ADDR_W'(i)) bus_rdata[CW-1:0] = cnt[i];
        end
      end
    endcase
  end

  // R8: no flag survives on a channel that is not running
  p_flag_only_active_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((flags & ~act_q) == '0));

  // R5: the force register never reads back a one
  p_force_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_addr == A_FORCE) |-> (bus_rdata == '0));

  // R9: interrupts never rise on a channel whose flag is clear
  p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((irq & ~flags) == '0));
endmodule

// File: tb/multi_tick_timer_test.sv
module multi_tick_timer_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [4:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic [7:0]  irq;

  always #2.5 clk = ~clk;

  multi_tick_timer uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  typedef struct {
    string       tag;
    logic [15:0] exp;
    logic [15:0] mask;
  } item_t;

  item_t queue_q[$];
  int    n_cmp  = 0;
  int    n_bad  = 0;
  bit    done   = 0;

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items and compares the read data
  initial begin
    item_t it;
    forever begin
      wait (queue_q.size() != 0);
      #1;
      it = queue_q.pop_front();
      check(it.tag, bus_rdata & it.mask, it.exp & it.mask);
    end
  end

  // driver tasks; each starts just after a falling edge
  task automatic wr(logic [4:0] a, logic [15:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, logic [15:0] e, logic [15:0] m, string tag);
    item_t it;
    bus_addr = a;
    it.tag = tag; it.exp = e; it.mask = m;
    queue_q.push_back(it);
    wait (queue_q.size() == 0);
  endtask

  task automatic peek(logic [4:0] a, output logic [15:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] ref_v;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    step(3);
    rst_n = 1'b1;
    step(4);

    // R1 reset state
    rd(5'h00, 16'h0, 16'hFFFF, "R1 run");
    rd(5'h01, 16'h0, 16'hFFFF, "R1 chen");
    rd(5'h02, 16'h0, 16'hFFFF, "R1 tbsel");
    rd(5'h04, 16'h0, 16'hFFFF, "R1 flags");
    rd(5'h10, 16'h0, 16'hFFFF, "R1 count0");
    check("R1 irq", {8'h0, irq}, 16'h0);

    // R10 configuration and readback
    wr(5'h06, 16'd0);
    wr(5'h07, 16'd3);
    wr(5'h02, 16'h0008);
    wr(5'h08, 16'd4);
    wr(5'h09, 16'd0);
    wr(5'h0A, 16'd9);
    wr(5'h0B, 16'd100);
    rd(5'h0B, 16'd100, 16'hFFFF, "R10 load3");
    rd(5'h07, 16'd3, 16'hFFFF, "R10 preB");
    rd(5'h02, 16'h0008, 16'hFFFF, "R10 tbsel");

    wr(5'h00, 16'h0001);

    // R5 force on a disabled channel does nothing; force reads zero
    wr(5'h03, 16'h0004);
    rd(5'h12, 16'd0, 16'hFFFF, "R5 force gated");
    rd(5'h03, 16'd0, 16'hFFFF, "R5 force reads zero");

    // R4 start load, R2 countdown and expiry
    wr(5'h01, 16'h0001);
    rd(5'h10, 16'd4, 16'hFFFF, "R4 start load");
    for (int k = 1; k <= 4; k++) begin
      step(1);
      rd(5'h10, 16'(4 - k), 16'hFFFF, "R2 countdown");
    end
    step(1);
    rd(5'h10, 16'd4, 16'hFFFF, "R2 reload at expiry");
    rd(5'h04, 16'h0001, 16'h0001, "R2 flag set");
    check("R9 irq masked", {15'h0, irq[0]}, 16'h0);

    // R9 interrupt enable
    wr(5'h05, 16'h0001);
    check("R9 irq raised", {15'h0, irq[0]}, 16'h1);

    // R6 write one to clear
    wr(5'h04, 16'h0001);
    rd(5'h04, 16'h0000, 16'h0001, "R6 flag cleared");
    rd(5'h10, 16'd2, 16'hFFFF, "R2 counting on");

    // R6 set wins over clear (reload 0 expires every tick)
    wr(5'h01, 16'h0003);
    step(1);
    rd(5'h04, 16'h0002, 16'h0002, "R6 ch1 flag set");
    wr(5'h04, 16'h0002);
    rd(5'h04, 16'h0002, 16'h0002, "R6 set beats clear");

    // R7 channel disable
    wr(5'h01, 16'h0002);
    rd(5'h04, 16'h0000, 16'h0001, "R7 flag cleared");
    check("R7 irq dropped", {15'h0, irq[0]}, 16'h0);
    peek(5'h10, ref_v);
    step(5);
    rd(5'h10, ref_v, 16'hFFFF, "R7 counter held");

    // R5 force on a running channel
    wr(5'h01, 16'h0006);
    rd(5'h12, 16'd9, 16'hFFFF, "R4 ch2 start");
    wr(5'h0A, 16'd20);
    rd(5'h12, 16'd8, 16'hFFFF, "R2 ch2 step");
    wr(5'h03, 16'h0004);
    rd(5'h12, 16'd20, 16'hFFFF, "R5 force load");
    step(1);
    rd(5'h12, 16'd19, 16'hFFFF, "R5 after force");
    wr(5'h03, 16'h0000);
    rd(5'h12, 16'd18, 16'hFFFF, "R5 zero no effect");

    // R3 time base B, prescale 3: 10 ticks in 40 clocks
    wr(5'h01, 16'h000E);
    rd(5'h13, 16'd100, 16'hFFFF, "R4 ch3 start");
    step(40);
    rd(5'h13, 16'd90, 16'hFFFF, "R3 base B rate");

    // R8 module stop
    wr(5'h00, 16'h0000);
    rd(5'h04, 16'h0000, 16'h00FF, "R8 flags cleared");
    peek(5'h13, ref_v);
    step(10);
    rd(5'h13, ref_v, 16'hFFFF, "R8 counter frozen");
    rd(5'h04, 16'h0000, 16'h00FF, "R8 flags stay clear");

    // R4 module restart reloads running channels
    wr(5'h00, 16'h0001);
    rd(5'h13, 16'd100, 16'hFFFF, "R4 restart ch3");
    rd(5'h12, 16'd20, 16'hFFFF, "R4 restart ch2");

    step(2);
    finish_run();
  end
endmodule